// File: doc/BRIEF.md
# Fundamental Reset Sequencer for a PCIe Root Port

This block sits beside a root port and owns the active-low fundamental reset line that goes to one downstream device. It keeps that line low until the supplies are reported good and the reference clock is reported stable. Each of these two conditions has its own minimum hold time. The block then releases the line and waits a fixed settling period. After that it watches the link-up indication from the link layer for a bounded time and reports one of two outcomes: the link came up, or it timed out.

Software can request a new reset cycle at any time once the line has been released. Losing power-good at any point sends the block straight back to holding and restarts every timer. Every delay is a parameter counted in clock cycles, and the defaults are derived from the clock frequency. The line is modelled as an open-drain pin: the block gives a drive enable, and the line is pulled high outside the block when that enable is off.

Top module: `fund_reset_seq`

## Requirements
- R1: After reset, and whenever the synchronized power-good is low, the block is holding: `rst_drive_en` = 1 and `status` = 0. When power-good falls, the block is holding again within three clock edges, and both hold timers restart from zero.
- R2: The line is not released until power-good has been high continuously for at least `HOLD_PWR_CYC` cycles.
- R3: The line is not released until the reference clock has been reported stable for at least `HOLD_REF_CYC` cycles. If the stable indication drops, this count restarts.
- R4: After release, `status` = 1 for `SETTLE_CYC` cycles, whatever the link-up input does. Then `status` = 2 (polling).
- R5: While polling, a synchronized link-up gives `status` = 3 with `done` = 1. If link-up is seen in the same cycle that the poll window expires, link-up wins.
- R6: If no link-up is seen within `POLL_CYC` polling cycles, the block gives `status` = 4 with `timeout` = 1 and `done` = 0.
- R7: `late_link` = 1 when link-up is first seen `READY_CYC` or more cycles after release. `late_link` = 0 when link-up was seen earlier than that. The flag clears at the next release.
- R8: A one-cycle `sw_rerun` in any state other than holding drives the line low again. The line is held for `HOLD_REF_CYC` cycles (the power timer is not re-run), and then the whole sequence runs again. A `sw_rerun` during holding has no effect.
- R9: Open-drain behaviour: `rst_drive_en` = 1 and `rst_line` = 0 while the reset is asserted. `rst_drive_en` = 0 and `rst_line` = 1 (the pulled-up level) once it is released.
- R10: `status` codes are 0 = holding, 1 = settling after release, 2 = polling, 3 = link up, 4 = timeout. At most one of `done`, `timeout` and `rst_drive_en` is high at a time.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Free-running clock |
| rst_n | input | 1 | Asynchronous active-low reset of the block |
| pwr_good | input | 1 | All supplies reported good (asynchronous) |
| refclk_ok | input | 1 | Reference clock reported stable (asynchronous) |
| sw_rerun | input | 1 | One-cycle request for a new reset cycle |
| link_up | input | 1 | Link-up status from the link layer (asynchronous) |
| rst_drive_en | output | 1 | 1 = pull the reset line low |
| rst_line | output | 1 | Level the reset line takes (0 asserted, 1 released) |
| status | output | 3 | Sequence status code |
| done | output | 1 | Link came up |
| timeout | output | 1 | Link did not come up in the poll window |
| late_link | output | 1 | Link-up arrived after the readiness window |

## Verification
The sharpest collision is a link-up that reaches the poller in the very cycle the poll window runs out. The bench finds the first cycle of polling from `status` and counts forward from it. It then raises `link_up` so that, after the two synchronizer stages, it lands on the last poll cycle, and it expects `status` 3. It repeats the run with link-up one cycle later and expects `status` 4. A second overlap is a software re-run request that arrives while the power-hold timer is still counting. The bench pulses it a few cycles before the release is due and checks that the release time does not move.

// File: rtl/fund_reset_pkg.sv
package fund_reset_pkg;

    typedef enum logic [2:0] {
        ST_HOLD   = 3'd0,
        ST_SETTLE = 3'd1,
        ST_POLL   = 3'd2,
        ST_UP     = 3'd3,
        ST_TOUT   = 3'd4
    } seq_state_e;

endpackage

// File: rtl/fund_reset_sync.sv
module fund_reset_sync #(
    parameter int W = 3
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] async_in,
    output logic [W-1:0] sync_out
);
    logic [W-1:0] meta_d, meta_q;
    logic [W-1:0] stab_d, stab_q;

    always_comb begin
        meta_d = async_in;
        stab_d = meta_q;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            meta_q <= '0;
            stab_q <= '0;
        end else begin
            meta_q <= meta_d;
            stab_q <= stab_d;
        end
    end

    assign sync_out = stab_q;
endmodule

// File: rtl/fund_reset_hold_timer.sv
module fund_reset_hold_timer #(
    parameter int LIMIT = 10
) (
    input  logic clk,
    input  logic rst_n,
    input  logic clr,
    input  logic en,
    output logic reached
);
    localparam int CW = $clog2(LIMIT + 1);

    logic [CW-1:0] cnt_d, cnt_q;

    always_comb begin
        cnt_d = cnt_q;
        if (clr) begin
            cnt_d = '0;
        end else if (en && (cnt_q < CW'(LIMIT))) begin
            cnt_d = cnt_q + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end

    assign reached = (cnt_q >= CW'(LIMIT));

    p_timer_bounded_r2: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_q <= CW'(LIMIT));

    p_timer_restart_r3: assert property (@(posedge clk) disable iff (!rst_n)
        clr |=> !reached);
endmodule

// File: rtl/fund_reset_seq.sv
module fund_reset_seq
    import fund_reset_pkg::*;
#(
    parameter int CLK_HZ       = 100_000_000,
    parameter int HOLD_PWR_CYC = CLK_HZ / 10,
    parameter int HOLD_REF_CYC = CLK_HZ / 10_000,
    parameter int SETTLE_CYC   = CLK_HZ / 10,
    parameter int POLL_CYC     = CLK_HZ / 5,
    parameter int READY_CYC    = CLK_HZ / 50
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       pwr_good,
    input  logic       refclk_ok,
    input  logic       sw_rerun,
    input  logic       link_up,
    output logic       rst_drive_en,
    output logic       rst_line,
    output logic [2:0] status,
    output logic       done,
    output logic       timeout,
    output logic       late_link
);
    localparam int TMAX = (SETTLE_CYC > POLL_CYC) ? SETTLE_CYC : POLL_CYC;
    localparam int TW   = $clog2(TMAX + 1);
    localparam int RW   = $clog2(READY_CYC + 1);

    typedef struct packed {
        seq_state_e    st;
        logic [TW-1:0] tcnt;
        logic [RW-1:0] rcnt;
        logic          seen;
        logic          late;
    } seq_t;

    seq_t seq_d, seq_q;

    logic [2:0] sync_v;
    logic       pwr_s, ref_s, link_s;
    logic       pwr_done, ref_done;
    logic       restart;
    logic       in_window;

    fund_reset_sync #(.W(3)) u_sync (
        .clk      (clk),
        .rst_n    (rst_n),
        .async_in ({link_up, refclk_ok, pwr_good}),
        .sync_out (sync_v)
    );

    assign pwr_s  = sync_v[0];
    assign ref_s  = sync_v[1];
    assign link_s = sync_v[2];

    assign restart = sw_rerun && (seq_q.st != ST_HOLD);

    fund_reset_hold_timer #(.LIMIT(HOLD_PWR_CYC)) u_pwr_timer (
        .clk     (clk),
        .rst_n   (rst_n),
        .clr     (!pwr_s),
        .en      (pwr_s),
        .reached (pwr_done)
    );

    fund_reset_hold_timer #(.LIMIT(HOLD_REF_CYC)) u_ref_timer (
        .clk     (clk),
        .rst_n   (rst_n),
        .clr     (!(pwr_s && ref_s) || restart),
        .en      (pwr_s && ref_s),
        .reached (ref_done)
    );

    assign in_window = (seq_q.rcnt < RW'(READY_CYC));

    always_comb begin
        seq_d = seq_q;
        if ((seq_q.st == ST_SETTLE) || (seq_q.st == ST_POLL)) begin
            if (in_window) seq_d.rcnt = seq_q.rcnt + 1'b1;
            if (link_s && in_window) seq_d.seen = 1'b1;
        end
        unique case (seq_q.st)
            ST_HOLD: begin
                if (pwr_s && ref_s && pwr_done && ref_done) begin
                    seq_d.st   = ST_SETTLE;
                    seq_d.tcnt = '0;
                    seq_d.rcnt = '0;
                    seq_d.seen = 1'b0;
                    seq_d.late = 1'b0;
                end
            end
            ST_SETTLE: begin
                if (seq_q.tcnt == TW'(SETTLE_CYC - 1)) begin
                    seq_d.st   = ST_POLL;
                    seq_d.tcnt = '0;
                end else begin
                    seq_d.tcnt = seq_q.tcnt + 1'b1;
                end
            end
            ST_POLL: begin
                if (link_s) begin
                    seq_d.st   = ST_UP;
                    seq_d.late = !(seq_q.seen || in_window);
                end else if (seq_q.tcnt == TW'(POLL_CYC - 1)) begin
                    seq_d.st = ST_TOUT;
                end else begin
                    seq_d.tcnt = seq_q.tcnt + 1'b1;
                end
            end
            default: ;
        endcase
        if (restart) seq_d.st = ST_HOLD;
        if (!pwr_s)  seq_d.st = ST_HOLD;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            seq_q <= '{st: ST_HOLD, tcnt: '0, rcnt: '0, seen: 1'b0, late: 1'b0};
        end else begin
            seq_q <= seq_d;
        end
    end

    assign rst_drive_en = (seq_q.st == ST_HOLD);
    assign rst_line     = !rst_drive_en;
    assign status       = seq_q.st;
    assign done         = (seq_q.st == ST_UP);
    assign timeout      = (seq_q.st == ST_TOUT);
    assign late_link    = seq_q.late;

    p_hold_on_power_loss_r1: assert property (@(posedge clk) disable iff (!rst_n)
        !pwr_s |=> rst_drive_en);

    p_release_after_power_r2: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(rst_drive_en) |-> $past(pwr_done));

    p_release_after_refclk_r3: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(rst_drive_en) |-> $past(ref_done));

    p_settle_length_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (seq_q.st == ST_POLL && $past(seq_q.st) == ST_SETTLE)
            |-> $past(seq_q.tcnt) == TW'(SETTLE_CYC - 1));

    p_timeout_only_from_poll_r6: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(timeout) |-> ($past(seq_q.st) == ST_POLL && !$past(link_s)));

    p_flags_exclusive_r10: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({done, timeout, rst_drive_en}));
endmodule

// File: tb/sim_fund_reset_seq.sv
module sim_fund_reset_seq;
    localparam int P = 40;
    localparam int C = 10;
    localparam int W = 30;
    localparam int Q = 50;
    localparam int R = 45;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       pwr_good = 1'b0;
    logic       refclk_ok = 1'b0;
    logic       sw_rerun = 1'b0;
    logic       link_up = 1'b0;
    logic       rst_drive_en, rst_line, done, timeout, late_link;
    logic [2:0] status;

    int checks = 0;
    int fails = 0;
    bit finished = 1'b0;

    always #5 clk = ~clk;

    fund_reset_seq #(
        .CLK_HZ(1000), .HOLD_PWR_CYC(P), .HOLD_REF_CYC(C),
        .SETTLE_CYC(W), .POLL_CYC(Q), .READY_CYC(R)
    ) u0 (
        .clk(clk), .rst_n(rst_n), .pwr_good(pwr_good), .refclk_ok(refclk_ok),
        .sw_rerun(sw_rerun), .link_up(link_up), .rst_drive_en(rst_drive_en),
        .rst_line(rst_line), .status(status), .done(done), .timeout(timeout),
        .late_link(late_link)
    );

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
        end
    endtask

    task automatic wait_status(input int code, input int lim, output int n);
        n = 0;
        do begin
            @(negedge clk);
            n++;
        end while ((int'(status) != code) && (n < lim));
    endtask

    task automatic pulse_rerun(input logic link_val);
        @(negedge clk);
        sw_rerun = 1'b1;
        link_up  = link_val;
        @(negedge clk);
        sw_rerun = 1'b0;
    endtask

    task automatic t_reset;
        repeat (4) @(negedge clk);
        chk(rst_drive_en == 1'b1 && rst_line == 1'b0, "R9 reset drive", rst_drive_en, 1);
        chk(status == 3'd0 && !done && !timeout, "R10 reset status", status, 0);
        rst_n = 1'b1;
        repeat (60) @(negedge clk);
        chk(rst_drive_en == 1'b1, "R1 no power keeps hold", rst_drive_en, 1);
    endtask

    task automatic t_power_up;
        int n;
        int k;
        pwr_good  = 1'b1;
        refclk_ok = 1'b1;
        n = 0;
        do begin
            @(negedge clk);
            n++;
        end while (rst_drive_en && n < 100);
        chk(n >= P && n <= P + 4, "R2 power hold length", n, P + 3);
        chk(rst_line == 1'b1 && rst_drive_en == 1'b0, "R9 released level", rst_line, 1);
        chk(status == 3'd1, "R10 settle code", status, 1);
        link_up = 1'b1;
        k = 1;
        forever begin
            @(negedge clk);
            if (status != 3'd1) break;
            k++;
        end
        chk(k >= W - 1 && k <= W + 1, "R4 settle ignores link", k, W);
        wait_status(3, 10, n);
        chk(status == 3'd3 && done, "R5 link up", status, 3);
        chk(late_link == 1'b0, "R7 in-window link", late_link, 0);
    endtask

    task automatic t_sw_rerun;
        int n;
        pulse_rerun(1'b0);
        chk(rst_drive_en == 1'b1 && status == 3'd0, "R8 rerun asserts", status, 0);
        n = 0;
        while (rst_drive_en && n < 100) begin
            @(negedge clk);
            n++;
        end
        chk(n >= C - 1 && n <= C + 2, "R8 rerun hold length", n, C);
    endtask

    task automatic t_timeout;
        int n;
        wait_status(4, W + Q + 20, n);
        chk(status == 3'd4 && timeout && !done, "R6 timeout", status, 4);
        chk(rst_drive_en == 1'b0, "R6 line stays released", rst_drive_en, 0);
    endtask

    task automatic t_late;
        int n;
        pulse_rerun(1'b0);
        wait_status(2, C + W + 20, n);
        repeat (20) @(negedge clk);
        link_up = 1'b1;
        wait_status(3, 10, n);
        chk(status == 3'd3 && done, "R5 late link accepted", status, 3);
        chk(late_link == 1'b1, "R7 late flag", late_link, 1);
    endtask

    task automatic t_collision;
        int n;
        pulse_rerun(1'b0);
        wait_status(2, C + W + 20, n);
        repeat (Q - 3) @(negedge clk);
        link_up = 1'b1;
        repeat (4) @(negedge clk);
        chk(status == 3'd3, "R5 link wins last poll cycle", status, 3);
        pulse_rerun(1'b0);
        wait_status(2, C + W + 20, n);
        repeat (Q - 2) @(negedge clk);
        link_up = 1'b1;
        repeat (4) @(negedge clk);
        chk(status == 3'd4, "R6 link one cycle too late", status, 4);
    endtask

    task automatic t_refclk_drop;
        int n;
        link_up = 1'b0;
        @(negedge clk);
        sw_rerun  = 1'b1;
        refclk_ok = 1'b0;
        @(negedge clk);
        sw_rerun = 1'b0;
        repeat (20) @(negedge clk);
        chk(rst_drive_en == 1'b1, "R3 unstable clock holds", rst_drive_en, 1);
        refclk_ok = 1'b1;
        n = 0;
        do begin
            @(negedge clk);
            n++;
        end while (rst_drive_en && n < 100);
        chk(n >= C && n <= C + 4, "R3 clock hold length", n, C + 3);
    endtask

    task automatic t_power_loss;
        int n;
        repeat (5) @(negedge clk);
        pwr_good = 1'b0;
        n = 0;
        do begin
            @(negedge clk);
            n++;
        end while (status != 3'd0 && n < 20);
        chk(n <= 4 && rst_drive_en, "R1 power loss reasserts", n, 3);
        repeat (10) @(negedge clk);
        pwr_good = 1'b1;
        n = 0;
        do begin
            @(negedge clk);
            n++;
            sw_rerun = (n == P - 4);
        end while (rst_drive_en && n < 100);
        sw_rerun = 1'b0;
        chk(n >= P && n <= P + 4, "R8 rerun ignored in hold / R1 timers restart", n, P + 3);
    endtask

    initial begin
        repeat (50000) @(posedge clk);
        if (!finished) begin
            fails++;
            $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
            $finish;
        end
    end

    initial begin
        t_reset();
        t_power_up();
        t_sw_rerun();
        t_timeout();
        t_late();
        t_collision();
        t_refclk_drop();
        t_power_loss();
        finished = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
        $finish;
    end
endmodule